// File: doc/BRIEF.md
# Tuning Register Load Controller

This block is the control-port front end of a direct digital synthesizer. Host data arrives on two paths. The parallel path fills a 32-bit parallel assembly register one bus word at a time. The serial path shifts a 32-bit serial assembly register one bit per clock while its enable is high. A load strobe and a 4-bit transfer code then copy one of those assembled values into a single destination register. The destinations are a 4-bit command register, two 32-bit frequency words, a 12-bit phase offset and a 20-bit modulation word. The synthesis datapath that consumes these registers is outside this block.

The command register sets how the controller itself works. Its bit 0 picks the width of the parallel bus. Its bit 3 decides whether the load strobe, the transfer code and the frequency select are first retimed through a four-stage synchronizer or are used directly. A transfer fires once for each rising edge of the load strobe, whichever path the strobe takes.

Top module: `tuning_load_ctrl`

## Requirements
- R1: After reset, every destination register and `fselOut` read zero, and the controller starts in 8-bit bus mode with the synchronizer in use.
- R2: With command bit 0 clear, each parallel write shifts the parallel assembly register left by 8 and places `dataIn[7:0]` in the low byte. `dataIn[15:8]` has no effect, so four writes fill 32 bits.
- R3: With command bit 0 set, each parallel write shifts the parallel assembly register left by 16 and places `dataIn[15:0]` in the low half, so two writes fill 32 bits.
- R4: While `serEn` is high, the serial assembly register shifts left by one on each clock and takes `serIn` as its new bit 0, so a 32-bit word is delivered MSB first.
- R5: While the effective load strobe is low, no destination register changes, whatever the transfer code.
- R6: Transfer codes 0000 to 0011 load `parAsm[3:0]` into `cmdReg`. No serial transfer can ever change `cmdReg`.
- R7: Codes 1000, 1001, 1010 and 1011 load the parallel assembly register into `freq0`, `freq1`, `phase` and `modAmp` respectively. The shorter destinations take the low-order bits.
- R8: Codes 1100, 1101, 1110 and 1111 load the serial assembly register into `freq0`, `freq1`, `phase` and `modAmp` respectively. The shorter destinations take the low-order bits.
- R9: Each rising edge of the effective load strobe causes exactly one transfer. Holding the strobe high does not repeat it, even when the assembly register changes in the meantime.
- R10: With command bit 3 clear, the destination changes on the fifth rising clock edge, counting the first edge that samples `loadIn` high as the first. With command bit 3 set, it changes on that first edge.
- R11: When a parallel write and a transfer from the parallel path fall on the same edge, the transfer takes the assembly register's content from before that write, and the write still takes effect.
- R12: `fselOut` follows `fselIn` through the same path as the load strobe. It is delayed by four clocks with the synchronizer and passed straight through without it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| dataIn | input | 16 | Parallel bus word |
| dataWr | input | 1 | Parallel write, one word per cycle high |
| serIn | input | 1 | Serial data bit |
| serEn | input | 1 | Serial shift enable |
| loadIn | input | 1 | Load strobe |
| codeIn | input | 4 | Transfer code (source and destination) |
| fselIn | input | 1 | Frequency select |
| fselOut | output | 1 | Retimed frequency select |
| cmdReg | output | 4 | Command register (bit0 bus width, bit3 synchronizer bypass) |
| freq0 | output | 32 | Frequency word 0 |
| freq1 | output | 32 | Frequency word 1 |
| phase | output | 12 | Phase offset |
| modAmp | output | 20 | Modulation word |

## Verification
A parallel bus write and a transfer whose source is the parallel assembly register can land on the same clock edge. The bench provokes this in bypass mode by raising `dataWr` and `loadIn` in the same cycle. It then checks that the destination received the old assembled value. A second transfer, made after the collision, shows that the word written in that cycle was still shifted in. The same overlap occurs when a command-register load changes the bus width during a write. The rule applied there is that the new width governs only later writes.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  localparam int BUS_W  = 16;
  localparam int ASM_W  = 32;
  localparam int CMD_W  = 4;
  localparam int FREQ_W = 32;
  localparam int PH_W   = 12;
  localparam int MOD_W  = 20;
  localparam int CODE_W = 4;

  // Command bit positions
  localparam int CMD_WIDE   = 0;
  localparam int CMD_BYPASS = 3;

  typedef struct packed {
    logic wrCmd;
    logic wrF0;
    logic wrF1;
    logic wrPh;
    logic wrMod;
    logic useSer;
  } xferStb_t;
endpackage

// File: rtl/tlc_control.sv
module tlc_control
  import tlc_pkg::*;
#(
  parameter int SYNC_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadIn,
  input  logic [CODE_W-1:0] codeIn,
  input  logic              fselIn,
  input  logic              bypass,
  output xferStb_t          stb,
  output logic              fselOut
);
  localparam int CTL_W = CODE_W + 2;

  logic [CTL_W-1:0] syncPipe [SYNC_DEPTH];
  logic [CTL_W-1:0] rawCtl, selCtl;
  logic             selLoad, loadPrev, loadRise;
  logic [CODE_W-1:0] selCode;

  assign rawCtl = {loadIn, fselIn, codeIn};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_DEPTH; i++) syncPipe[i] <= '0;
    end else begin
      syncPipe[0] <= rawCtl;
      for (int i = 1; i < SYNC_DEPTH; i++) syncPipe[i] <= syncPipe[i-1];
    end
  end

  assign selCtl  = bypass ? rawCtl : syncPipe[SYNC_DEPTH-1];
  assign selLoad = selCtl[CTL_W-1];
  assign fselOut = selCtl[CTL_W-2];
  assign selCode = selCtl[CODE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) loadPrev <= 1'b0;
    else       loadPrev <= selLoad;
  end

  assign loadRise = selLoad & ~loadPrev;

  always_comb begin
    stb        = '0;
    stb.useSer = selCode[2];
    if (loadRise) begin
      if (!selCode[3]) stb.wrCmd = 1'b1;
      else begin
        unique case (selCode[1:0])
          2'b00: stb.wrF0  = 1'b1;
          2'b01: stb.wrF1  = 1'b1;
          2'b10: stb.wrPh  = 1'b1;
          default: stb.wrMod = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/tlc_datapath.sv
module tlc_datapath
  import tlc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_W-1:0]  dataIn,
  input  logic              dataWr,
  input  logic              serIn,
  input  logic              serEn,
  input  xferStb_t          stb,
  output logic [ASM_W-1:0]  parAsm,
  output logic [ASM_W-1:0]  serAsm,
  output logic [CMD_W-1:0]  cmdReg,
  output logic [FREQ_W-1:0] freq0,
  output logic [FREQ_W-1:0] freq1,
  output logic [PH_W-1:0]   phase,
  output logic [MOD_W-1:0]  modAmp
);
  localparam int HALF_W = BUS_W / 2;

  logic [ASM_W-1:0] srcWord;

  always_ff @(posedge clk) begin
    if (!rstN) parAsm <= '0;
    else if (dataWr) begin
      if (cmdReg[CMD_WIDE]) parAsm <= {parAsm[ASM_W-BUS_W-1:0], dataIn};
      else                  parAsm <= {parAsm[ASM_W-HALF_W-1:0], dataIn[HALF_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)      serAsm <= '0;
    else if (serEn) serAsm <= {serAsm[ASM_W-2:0], serIn};
  end

  assign srcWord = stb.useSer ? serAsm : parAsm;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg <= '0;
      freq0  <= '0;
      freq1  <= '0;
      phase  <= '0;
      modAmp <= '0;
    end else begin
      if (stb.wrCmd) cmdReg <= parAsm[CMD_W-1:0];
      if (stb.wrF0)  freq0  <= srcWord[FREQ_W-1:0];
      if (stb.wrF1)  freq1  <= srcWord[FREQ_W-1:0];
      if (stb.wrPh)  phase  <= srcWord[PH_W-1:0];
      if (stb.wrMod) modAmp <= srcWord[MOD_W-1:0];
    end
  end
endmodule

// File: rtl/tuning_load_ctrl.sv
module tuning_load_ctrl
  import tlc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_W-1:0]  dataIn,
  input  logic              dataWr,
  input  logic              serIn,
  input  logic              serEn,
  input  logic              loadIn,
  input  logic [CODE_W-1:0] codeIn,
  input  logic              fselIn,
  output logic              fselOut,
  output logic [CMD_W-1:0]  cmdReg,
  output logic [FREQ_W-1:0] freq0,
  output logic [FREQ_W-1:0] freq1,
  output logic [PH_W-1:0]   phase,
  output logic [MOD_W-1:0]  modAmp
);
  xferStb_t         xferStb;
  logic [ASM_W-1:0] parAsm;
  logic [ASM_W-1:0] serAsm;

  tlc_control #(.SYNC_DEPTH(4)) uCtl (
    .clk(clk), .rstN(rstN), .loadIn(loadIn), .codeIn(codeIn), .fselIn(fselIn),
    .bypass(cmdReg[CMD_BYPASS]), .stb(xferStb), .fselOut(fselOut)
  );

  tlc_datapath uDp (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .dataWr(dataWr),
    .serIn(serIn), .serEn(serEn), .stb(xferStb),
    .parAsm(parAsm), .serAsm(serAsm), .cmdReg(cmdReg),
    .freq0(freq0), .freq1(freq1), .phase(phase), .modAmp(modAmp)
  );
endmodule

// File: rtl/tlc_checker.sv
module tlc_checker
  import tlc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input xferStb_t          stb,
  input logic [BUS_W-1:0]  dataIn,
  input logic              dataWr,
  input logic              serIn,
  input logic              serEn,
  input logic              loadIn,
  input logic [ASM_W-1:0]  parAsm,
  input logic [ASM_W-1:0]  serAsm,
  input logic [CMD_W-1:0]  cmdReg,
  input logic [FREQ_W-1:0] freq0,
  input logic [FREQ_W-1:0] freq1,
  input logic [PH_W-1:0]   phase,
  input logic [MOD_W-1:0]  modAmp
);
  logic [4:0] wrVec;
  assign wrVec = {stb.wrCmd, stb.wrF0, stb.wrF1, stb.wrPh, stb.wrMod};

  assert_byte_shift_R2: assert property (@(posedge clk) disable iff (!rstN)
    dataWr && !cmdReg[CMD_WIDE] |=> parAsm[7:0] == $past(dataIn[7:0]));

  assert_half_shift_R3: assert property (@(posedge clk) disable iff (!rstN)
    dataWr && cmdReg[CMD_WIDE] |=> parAsm[15:0] == $past(dataIn));

  assert_ser_shift_R4: assert property (@(posedge clk) disable iff (!rstN)
    serEn |=> serAsm[0] == $past(serIn));

  assert_idle_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmdReg[CMD_BYPASS] && !loadIn |=>
      $stable(freq0) && $stable(freq1) && $stable(phase) && $stable(modAmp));

  assert_cmd_src_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCmd |=> cmdReg == $past(parAsm[CMD_W-1:0]));

  assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrCmd |=> $stable(cmdReg));

  assert_one_dest_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrVec));

  assert_no_repeat_R9: assert property (@(posedge clk) disable iff (!rstN)
    (|wrVec) |=> !(|wrVec));
endmodule

bind tuning_load_ctrl tlc_checker chk (
  .clk(clk), .rstN(rstN), .stb(xferStb), .dataIn(dataIn), .dataWr(dataWr),
  .serIn(serIn), .serEn(serEn), .loadIn(loadIn), .parAsm(parAsm), .serAsm(serAsm),
  .cmdReg(cmdReg), .freq0(freq0), .freq1(freq1), .phase(phase), .modAmp(modAmp)
);

// File: tb/tuning_load_ctrl_test.sv
module tuning_load_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] dataIn = '0;
  logic        dataWr = 1'b0;
  logic        serIn = 1'b0;
  logic        serEn = 1'b0;
  logic        loadIn = 1'b0;
  logic [3:0]  codeIn = '0;
  logic        fselIn = 1'b0;
  logic        fselOut;
  logic [3:0]  cmdReg;
  logic [31:0] freq0, freq1;
  logic [11:0] phase;
  logic [19:0] modAmp;

  int errors = 0;
  int checks = 0;

  logic [31:0] mPar = '0;
  logic [31:0] mSer = '0;
  logic [31:0] mF0 = '0, mF1 = '0;
  logic [11:0] mPh = '0;
  logic [19:0] mMod = '0;
  logic        wide = 1'b0;

  always #5 clk = ~clk;

  tuning_load_ctrl uut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .dataWr(dataWr), .serIn(serIn),
    .serEn(serEn), .loadIn(loadIn), .codeIn(codeIn), .fselIn(fselIn),
    .fselOut(fselOut), .cmdReg(cmdReg), .freq0(freq0), .freq1(freq1),
    .phase(phase), .modAmp(modAmp)
  );

  typedef struct packed {
    logic        doLoad;
    logic [3:0]  code;
    logic [31:0] par;
    logic [31:0] ser;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 4'b1010, 32'hFFFF_F123, 32'h0000_0000},
    '{1'b1, 4'b1011, 32'h00AB_CDEF, 32'h7777_7777},
    '{1'b1, 4'b1100, 32'h1111_1111, 32'h89AB_CDEF},
    '{1'b1, 4'b1101, 32'h2222_2222, 32'h0F0F_0F0F},
    '{1'b1, 4'b1110, 32'h3333_3333, 32'hFFFF_F456},
    '{1'b1, 4'b1111, 32'h4444_4444, 32'h1234_5678},
    '{1'b0, 4'b1000, 32'hDEAD_BEEF, 32'hCAFE_F00D},
    '{1'b0, 4'b0000, 32'h0000_0000, 32'h5555_5555}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic parWrite(input logic [15:0] d);
    @(negedge clk);
    dataIn = d;
    dataWr = 1'b1;
    mPar = wide ? {mPar[15:0], d} : {mPar[23:0], d[7:0]};
    @(negedge clk);
    dataWr = 1'b0;
  endtask

  task automatic serWord(input logic [31:0] v);
    for (int i = 31; i >= 0; i--) begin
      @(negedge clk);
      serEn = 1'b1;
      serIn = v[i];
    end
    @(negedge clk);
    serEn = 1'b0;
    mSer = v;
  endtask

  task automatic loadPulse(input logic [3:0] code, input int settle);
    @(negedge clk);
    loadIn = 1'b1;
    codeIn = code;
    @(negedge clk);
    loadIn = 1'b0;
    repeat (settle) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 cmdReg", {28'h0, cmdReg}, 32'h0);
    check("R1 freq0", freq0, 32'h0);
    check("R1 freq1", freq1, 32'h0);
    check("R1 phase", {20'h0, phase}, 32'h0);
    check("R1 modAmp", {12'h0, modAmp}, 32'h0);
    check("R1 fselOut", {31'h0, fselOut}, 32'h0);

    // R2: 8-bit mode, upper byte is junk
    parWrite(16'hAA12); parWrite(16'hBB34); parWrite(16'hCC56); parWrite(16'hDD78);
    check("R2 model", mPar, 32'h1234_5678);

    // R10/R12: synchronized path latency
    @(negedge clk);
    loadIn = 1'b1; codeIn = 4'b1000; fselIn = 1'b1;
    repeat (3) @(negedge clk);
    check("R12 fsel after 3 edges", {31'h0, fselOut}, 32'h0);
    @(negedge clk);
    check("R12 fsel after 4 edges", {31'h0, fselOut}, 32'h1);
    check("R10 freq0 not yet at 4th edge", freq0, 32'h0);
    @(negedge clk);
    check("R10 freq0 at 5th edge", freq0, 32'h1234_5678);
    check("R2 freq0 bytes", freq0, 32'h1234_5678);
    mF0 = 32'h1234_5678;
    // R9: strobe held, assembly changes, no repeat
    parWrite(16'h0099);
    repeat (8) @(negedge clk);
    check("R9 held strobe no repeat", freq0, mF0);
    loadIn = 1'b0;
    repeat (6) @(negedge clk);

    // R6: command = bypass + 16-bit
    parWrite(16'h0000); parWrite(16'h0000); parWrite(16'h0000); parWrite(16'h0009);
    loadPulse(4'b0001, 6);
    check("R6 cmd load", {28'h0, cmdReg}, 32'h9);
    wide = 1'b1;

    // R12 bypass: immediate
    @(negedge clk); fselIn = 1'b0; #1;
    check("R12 fsel bypass", {31'h0, fselOut}, 32'h0);

    // R3 and R10 bypass latency
    parWrite(16'h1234); parWrite(16'hABCD);
    @(negedge clk);
    loadIn = 1'b1; codeIn = 4'b1001;
    @(negedge clk);
    loadIn = 1'b0;
    check("R10 bypass one edge", freq1, 32'h1234_ABCD);
    check("R3 16-bit assembly", freq1, 32'h1234_ABCD);
    mF1 = 32'h1234_ABCD;

    // Vector table in bypass mode
    for (int v = 0; v < NVEC; v++) begin
      string tag;
      parWrite(VECS[v].par[31:16]);
      parWrite(VECS[v].par[15:0]);
      serWord(VECS[v].ser);
      tag = !VECS[v].doLoad ? "R5" : (VECS[v].code[2] ? "R8" : "R7");
      @(negedge clk);
      loadIn = VECS[v].doLoad;
      codeIn = VECS[v].code;
      @(negedge clk);
      loadIn = 1'b0;
      @(negedge clk);
      if (VECS[v].doLoad) begin
        logic [31:0] src;
        src = VECS[v].code[2] ? mSer : mPar;
        case (VECS[v].code[1:0])
          2'b00: mF0 = src;
          2'b01: mF1 = src;
          2'b10: mPh = src[11:0];
          default: mMod = src[19:0];
        endcase
      end
      check({tag, " freq0"}, freq0, mF0);
      check({tag, " freq1"}, freq1, mF1);
      check({tag, " phase"}, {20'h0, phase}, {20'h0, mPh});
      check({tag, " modAmp"}, {12'h0, modAmp}, {12'h0, mMod});
      check({tag, " cmdReg (R6 serial never)"}, {28'h0, cmdReg}, 32'h9);
    end

    // R4: serial word lands MSB first (transfer to freq0)
    serWord(32'h8000_0001);
    loadPulse(4'b1100, 1);
    check("R4 serial order", freq0, 32'h8000_0001);

    // R11: same-cycle parallel write and transfer
    begin
      logic [31:0] oldPar;
      oldPar = mPar;
      @(negedge clk);
      dataIn = 16'h5555; dataWr = 1'b1;
      loadIn = 1'b1; codeIn = 4'b1000;
      mPar = {mPar[15:0], 16'h5555};
      @(negedge clk);
      dataWr = 1'b0; loadIn = 1'b0;
      check("R11 transfer sees old value", freq0, oldPar);
      loadPulse(4'b1001, 1);
      check("R11 write still applied", freq1, mPar);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule